// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port with Pull-Ups and Change Listeners

This block is a general-purpose I/O port. A register bus sets, for each pin, whether the processor drives it and whether it has a pull-up, and it holds the value the processor drives. On-chip peripherals can also drive pins through their own direction and data inputs. The visible level of each pin is a wired-OR of three things:
- the processor's drive,
- the peripheral's drive,
- the pull-up, on a pin that neither side drives.

The port watches these resolved levels from cycle to cycle. Each change is offered to up to four listeners. Each listener has a trigger mask, and it is notified only when a masked pin has toggled. If a notified listener answers with a request, and the interrupt is enabled, the port emits a one-cycle interrupt pulse.

The bus works as a request/response stream with no back-pressure. The port accepts a request in every cycle where `bus_sel` is high; in effect it is always ready. A read returns its data one cycle later, marked by `bus_rvalid`. Writes return no response.

Register offsets, on the 2-bit `bus_addr`:
- 0 is the pin control word.
- 1 is the pin data.
- 2 is the interrupt configuration.
- 3 is the interrupt enable, in bit 0.

Top module: `gpio_port`

## Requirements
- R1: After reset the control, data and enable registers are zero, every resolved level is 0, `port_irq` and `cfg_err` are low, and reads of offsets 0 and 1 return 0.
- R2: In the 32-bit control word at offset 0, bit 2n makes the processor drive pin n and bit 2n+1 enables the pull-up of pin n. A write to offset 0 updates `pin_level` in the cycle after the write edge.
- R3: Pin n resolves to (cpu_dir[n] & cpu_data[n]) | (periph_dir[n] & periph_data[n]) | (~(cpu_dir[n] | periph_dir[n]) & pullup[n]). Here cpu_data is bits 15:0 last written to offset 1.
- R4: A read of offset 1 returns the resolved levels in bits 15:0 with zeros above, not the value last written. A read of offset 0 returns the control word. Read data appears with `bus_rvalid` high for one cycle, starting the cycle after the request edge.
- R5: The change vector is the XOR of the resolved levels in one cycle and in the cycle before. When the levels are equal, no listener is notified; for example, rewriting the same data gives no notification.
- R6: `lst_notify[i]` is high, for exactly the cycle in which the new levels first appear, if and only if listener i's 16-bit field of `lst_mask` (bits 16i+15:16i) ANDed with the change vector is nonzero.
- R7: `port_irq` pulses high for one cycle, one cycle after a notification, when the enable bit is set and a notified listener holds its `lst_req` bit high. When the enable bit is clear, there is no pulse.
- R8: `periph_dir` and `periph_data` are registered on each clock edge. A change on them moves `pin_level` one cycle later and runs the same change detection as a register write.
- R9: Writing a nonzero value to offset 2 sets `cfg_err`, and `cfg_err` then stays high until reset. Writing zero leaves it unchanged. Offset 2 reads back bits 15:0 of the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus request valid, always accepted |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| periph_dir | input | 16 | Peripheral drive enable per pin |
| periph_data | input | 16 | Peripheral drive value per pin |
| lst_mask | input | 64 | Four 16-bit trigger masks, listener i in bits 16i+15:16i |
| lst_req | input | 4 | Listener request, sampled while notified |
| lst_notify | output | 4 | Per-listener change notification |
| pin_level | output | 16 | Resolved pin levels |
| port_irq | output | 1 | One-cycle change interrupt pulse |
| cfg_err | output | 1 | Sticky unsupported-configuration flag |

## Verification
Some rules are checked by the assertions on every cycle:
- notifications occur only when `pin_level` differs from its previous value, and never while it holds;
- an interrupt pulse always follows a cycle in which a notified listener requested;
- `cfg_err` never falls;
- each read request is followed by exactly one response;
- the port comes out of reset quiet.

Other behaviour only the bench scenarios can show:
- the resolution formula itself, across swept control, data and peripheral patterns;
- the bit positions in the control word;
- the exact notification set for each listener mask;
- the effect of the enable bit;
- the readback of levels instead of written data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CTRL = 2'd0,
    OFS_DATA = 2'd1,
    OFS_ICFG = 2'd2,
    OFS_IEN  = 2'd3
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic [NPINS-1:0]    level,
  output logic [2*NPINS-1:0]  ctrl_q,
  output logic [NPINS-1:0]    data_q,
  output logic                irq_en,
  output logic                cfg_err,
  output logic                bus_rvalid,
  output logic [BUS_W-1:0]    bus_rdata
);
  localparam int CTRL_W = 2 * NPINS;
  localparam int PAD_L  = BUS_W - NPINS;
  localparam int PAD_C  = BUS_W - CTRL_W;

  logic [NPINS-1:0] icfg_q;
  logic             wr_en;
  logic             rd_en;
  logic [BUS_W-1:0] rd_mux;
  gpio_ofs_e        ofs;

  assign ofs   = gpio_ofs_e'(bus_addr);
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      data_q  <= '0;
      icfg_q  <= '0;
      irq_en  <= 1'b0;
      cfg_err <= 1'b0;
    end else if (wr_en) begin
      case (ofs)
        OFS_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
        OFS_DATA: data_q <= bus_wdata[NPINS-1:0];
        OFS_ICFG: begin
          icfg_q <= bus_wdata[NPINS-1:0];
          if (bus_wdata[NPINS-1:0] != '0) cfg_err <= 1'b1;
        end
        OFS_IEN:  irq_en <= bus_wdata[0];
        default:  ;
      endcase
    end
  end

  // Read mux: the data offset returns resolved levels
  always_comb begin
    case (ofs)
      OFS_CTRL: rd_mux = {{PAD_C{1'b0}}, ctrl_q};
      OFS_DATA: rd_mux = {{PAD_L{1'b0}}, level};
      OFS_ICFG: rd_mux = {{PAD_L{1'b0}}, icfg_q};
      OFS_IEN:  rd_mux = {{(BUS_W-1){1'b0}}, irq_en};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_resolve.sv
module gpio_resolve #(
  parameter int NPINS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NPINS-1:0] ctrl_q,
  input  logic [NPINS-1:0]   data_q,
  input  logic [NPINS-1:0]   periph_dir,
  input  logic [NPINS-1:0]   periph_data,
  output logic [NPINS-1:0]   level
);
  logic [NPINS-1:0] pdir_q;
  logic [NPINS-1:0] pdat_q;

  // Peripheral drive is registered once per clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdir_q <= '0;
      pdat_q <= '0;
    end else begin
      pdir_q <= periph_dir;
      pdat_q <= periph_data;
    end
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic cpu_oe;
    logic pull_en;
    assign cpu_oe   = ctrl_q[2*n];
    assign pull_en  = ctrl_q[2*n+1];
    assign level[n] = (cpu_oe & data_q[n])
                    | (pdir_q[n] & pdat_q[n])
                    | (~(cpu_oe | pdir_q[n]) & pull_en);
  end
endmodule

// File: rtl/gpio_change.sv
module gpio_change #(
  parameter int NPINS = 16,
  parameter int NLST  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      level,
  input  logic [NLST*NPINS-1:0] lst_mask,
  input  logic [NLST-1:0]       lst_req,
  input  logic                  irq_en,
  output logic [NLST-1:0]       lst_notify,
  output logic                  port_irq
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] toggled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign toggled = level ^ prev_q;

  for (genvar i = 0; i < NLST; i++) begin : g_lst
    assign lst_notify[i] = |(lst_mask[i*NPINS +: NPINS] & toggled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_irq <= 1'b0;
    else        port_irq <= irq_en & (|(lst_notify & lst_req));
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int NLST  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic                  bus_rvalid,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [NPINS-1:0]      periph_dir,
  input  logic [NPINS-1:0]      periph_data,
  input  logic [NLST*NPINS-1:0] lst_mask,
  input  logic [NLST-1:0]       lst_req,
  output logic [NLST-1:0]       lst_notify,
  output logic [NPINS-1:0]      pin_level,
  output logic                  port_irq,
  output logic                  cfg_err
);
  logic [2*NPINS-1:0] ctrl_q;
  logic [NPINS-1:0]   data_q;
  logic               irq_en;

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .level(pin_level),
    .ctrl_q(ctrl_q), .data_q(data_q), .irq_en(irq_en), .cfg_err(cfg_err),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  gpio_resolve #(.NPINS(NPINS)) u_resolve (
    .clk(clk), .rst_n(rst_n),
    .ctrl_q(ctrl_q), .data_q(data_q),
    .periph_dir(periph_dir), .periph_data(periph_data),
    .level(pin_level)
  );

  gpio_change #(.NPINS(NPINS), .NLST(NLST)) u_change (
    .clk(clk), .rst_n(rst_n),
    .level(pin_level), .lst_mask(lst_mask), .lst_req(lst_req),
    .irq_en(irq_en), .lst_notify(lst_notify), .port_irq(port_irq)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NPINS = 16,
  parameter int NLST  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic             bus_rvalid,
  input logic [NLST-1:0]  lst_req,
  input logic [NLST-1:0]  lst_notify,
  input logic [NPINS-1:0] pin_level,
  input logic             port_irq,
  input logic             cfg_err
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_level == '0 && !port_irq && !cfg_err && !bus_rvalid));

  a_r5_no_change_no_notify: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pin_level) |-> (lst_notify == '0));

  a_r6_notify_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (lst_notify != '0) |-> (pin_level != $past(pin_level)));

  a_r7_irq_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    port_irq |-> $past((lst_notify & lst_req) != '0));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r4_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  a_r4_no_spurious_response: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_sel && !bus_wr));
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .NLST(NLST)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rvalid(bus_rvalid), .lst_req(lst_req), .lst_notify(lst_notify),
  .pin_level(pin_level), .port_irq(port_irq), .cfg_err(cfg_err)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] periph_dir = '0;
  logic [NP-1:0] periph_data = '0;
  logic [NL*NP-1:0] lst_mask = '0;
  logic [NL-1:0] lst_req = '0;
  logic [NL-1:0] lst_notify;
  logic [NP-1:0] pin_level;
  logic          port_irq;
  logic          cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model
  logic [31:0]   m_ctrl = '0;
  logic [NP-1:0] m_data = '0;
  logic [NP-1:0] m_pdir = '0;
  logic [NP-1:0] m_pdat = '0;
  logic          m_en = 1'b0;
  logic [31:0]   lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .periph_dir(periph_dir), .periph_data(periph_data),
    .lst_mask(lst_mask), .lst_req(lst_req), .lst_notify(lst_notify),
    .pin_level(pin_level), .port_irq(port_irq), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] resolve(input logic [31:0] c, input logic [NP-1:0] d,
                                            input logic [NP-1:0] pd, input logic [NP-1:0] pv);
    logic [NP-1:0] r;
    for (int n = 0; n < NP; n++) begin
      logic oe, pu;
      oe = c[2*n];
      pu = c[2*n+1];
      r[n] = (oe & d[n]) | (pd[n] & pv[n]) | (~(oe | pd[n]) & pu);
    end
    return r;
  endfunction

  function automatic logic [31:0] next_lfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    check({req, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
    check({req, " rdata"}, bus_rdata, exp);
  endtask

  // kind 0: control write, 1: data write, 2: peripheral drive {data, dir}
  task automatic step(input int kind, input logic [31:0] v);
    logic [NP-1:0] old_l, new_l, chg;
    logic [NL-1:0] exp_n;
    old_l = resolve(m_ctrl, m_data, m_pdir, m_pdat);
    case (kind)
      0: begin m_ctrl = v; bus_write(2'd0, v); end
      1: begin m_data = v[NP-1:0]; bus_write(2'd1, v); end
      default: begin
        m_pdir = v[NP-1:0]; m_pdat = v[31:16];
        @(negedge clk);
        periph_dir = m_pdir; periph_data = m_pdat;
        @(negedge clk);
      end
    endcase
    new_l = resolve(m_ctrl, m_data, m_pdir, m_pdat);
    chg = old_l ^ new_l;
    for (int i = 0; i < NL; i++) exp_n[i] = |(lst_mask[i*NP +: NP] & chg);
    check(kind == 2 ? "R8 level after peripheral change" : "R3 resolved level",
          {16'd0, pin_level}, {16'd0, new_l});
    check("R6 listener notify", {28'd0, lst_notify}, {28'd0, exp_n});
    @(negedge clk);
    check("R7 irq pulse", {31'd0, port_irq}, {31'd0, m_en & (|(exp_n & lst_req))});
    check("R5 quiet after change", {28'd0, lst_notify}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    lst_mask = {16'h0000, 16'hF000, 16'h00F0, 16'h000F};
    lst_req  = 4'b0101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 level", {16'd0, pin_level}, 32'd0);
    check("R1 irq", {31'd0, port_irq}, 32'd0);
    check("R1 err", {31'd0, cfg_err}, 32'd0);
    bus_read(2'd0, 32'd0, "R1 ctrl read");
    bus_read(2'd1, 32'd0, "R1 data read");

    bus_write(2'd3, 32'd1);
    m_en = 1'b1;

    // R2 per-pin bit positions: drive then pull-up
    for (int n = 0; n < NP; n++) begin
      step(1, 32'h0000_FFFF);
      step(0, 32'd1 << (2*n));
      check("R2 drive bit position", {16'd0, pin_level}, 32'd1 << n);
      step(1, 32'd0);
      step(0, 32'd1 << (2*n+1));
      check("R2 pull-up bit position", {16'd0, pin_level}, 32'd1 << n);
    end
    bus_read(2'd0, 32'd1 << (2*NP-1), "R4 ctrl readback");

    // R5 rewriting same data: no notification
    step(0, 32'h5555_5555);
    step(1, 32'h0000_A5A5);
    step(1, 32'h0000_A5A5);
    // R4 readback is level, not written value
    step(0, 32'hAAAA_AAAA);
    bus_read(2'd1, 32'h0000_FFFF, "R4 data read shows levels");

    // Pseudo-random sweep of all three sources
    for (int k = 0; k < 300; k++) begin
      lfsr = next_lfsr(lfsr);
      step(k % 3, lfsr);
      if (k % 10 == 0)
        bus_read(2'd1, {16'd0, resolve(m_ctrl, m_data, m_pdir, m_pdat)}, "R4 data read");
    end

    // R7 disabled: notification still occurs, no irq
    bus_write(2'd3, 32'd0);
    m_en = 1'b0;
    step(2, 32'h0000_0000);
    step(0, 32'h0000_0055);
    step(1, 32'h0000_000F);

    // R9 sticky error flag
    bus_write(2'd2, 32'd0);
    @(negedge clk);
    check("R9 zero write no err", {31'd0, cfg_err}, 32'd0);
    bus_write(2'd2, 32'h0000_0005);
    check("R9 nonzero sets err", {31'd0, cfg_err}, 32'd1);
    bus_write(2'd2, 32'd0);
    check("R9 err sticky", {31'd0, cfg_err}, 32'd1);
    bus_read(2'd2, 32'd0, "R9 icfg readback");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule